// File: doc/BRIEF.md
# Windowed Watchdog with Early Warning

This block supervises software timing with a 7-bit down counter that steps on a divided copy of the bus clock. Software must reload (refresh) the counter inside a time window: a refresh made while the counter still sits above a programmable window value is treated as premature and requests a system reset, and a counter that runs down far enough to clear its top bit requests a system reset as well. A refresh that would clear that top bit also requests a reset at once.

One step before expiry, when the counter reaches 0x40, the block sets a warning flag. If enabled, that flag drives an interrupt so that software gets a last chance to refresh. The flag stays set until software clears it. The enable bit can only be set by software and only a system reset clears it. The bus fabric and the interrupt controller sit outside this block. A write strobe plus a data word per register is the whole register access.

Top module: `win_wdog`

## Requirements
- R1: After rst_ni the counter reads 0x7F, the enable is 0, the warning flag is 0, and irq_o and sys_rst_o are low. The configuration resets to window 0x7F, prescale code 0 and interrupt off.
- R2: A control write loads ctl_wdata_i[6:0] into the counter and sets the enable when ctl_wdata_i[7] is 1. A write with bit 7 at 0 never clears an enable that is already set.
- R3: While the enable is 0, the counter holds its value and no reset is requested.
- R4: While enabled, the counter decrements once every 2^(PRE_LOG2+tb) clocks, where tb is cfg_wdata_i[8:7]. A control write restarts the divider, so the first decrement comes that many clocks after the write.
- R5: When the counter steps from 0x40 to 0x3F, sys_rst_o is high for exactly the next clock cycle.
- R6: A control write made while enabled and while the counter is greater than the window value cfg_wdata_i[6:0] raises sys_rst_o in the following cycle.
- R7: A control write made while the counter is at or below the window value loads the counter and raises no reset.
- R8: A control write that leaves the enable set with ctl_wdata_i[6] at 0 raises sys_rst_o in the following cycle.
- R9: The warning flag is set when a decrement brings the counter to 0x40. A status write with sts_wdata_i at 0 clears it, a status write with 1 leaves it unchanged, and a set wins over a clear in the same cycle.
- R10: irq_o equals the warning flag gated by the interrupt enable cfg_wdata_i[9].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Bus clock |
| rst_ni | input | 1 | Active-low asynchronous system reset |
| ctl_we_i | input | 1 | Control register write strobe (refresh) |
| ctl_wdata_i | input | 8 | [7] enable, [6:0] counter load value |
| cfg_we_i | input | 1 | Configuration register write strobe |
| cfg_wdata_i | input | 10 | [9] interrupt enable, [8:7] prescale code, [6:0] window |
| sts_we_i | input | 1 | Status write strobe |
| sts_wdata_i | input | 1 | Written 0 clears the warning flag |
| cnt_o | output | 7 | Current counter value |
| en_o | output | 1 | Watchdog enable |
| ewi_flag_o | output | 1 | Early warning flag |
| irq_o | output | 1 | Early warning interrupt |
| sys_rst_o | output | 1 | One-cycle system reset request |

## Verification
A divider that is off by one count shows on cnt_o within one tick period after any refresh, because the first decrement lands on the wrong clock. A wrong window comparison or a wrong top-bit check shows as a missing or extra sys_rst_o pulse in the cycle right after the offending refresh. A flag or expiry decoded from the wrong counter value moves ewi_flag_o and the expiry pulse by a whole tick period, so the bench samples these outputs one cycle before and at their expected cycles. Random refreshes at random tick counts against random windows cover both sides of the window boundary.

// File: rtl/wdg_pkg.sv
package wdg_pkg;
  localparam int unsigned CNT_W = 7;
  localparam int unsigned TB_W  = 2;
  localparam int unsigned CTL_W = CNT_W + 1;

  localparam logic [CNT_W-1:0] CNT_RST  = '1;
  // value whose next decrement clears the top bit
  localparam logic [CNT_W-1:0] CNT_EDGE = CNT_W'(1) << (CNT_W - 1);

  typedef struct packed {
    logic            irq_en;
    logic [TB_W-1:0] tb;
    logic [CNT_W-1:0] win;
  } cfg_t;

  localparam int unsigned CFG_W = $bits(cfg_t);
endpackage

// File: rtl/wdg_prescaler.sv
module wdg_prescaler
  import wdg_pkg::*;
#(
  parameter int unsigned PRE_LOG2 = 12
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            run_i,
  input  logic            clr_i,
  input  logic [TB_W-1:0] tb_i,
  output logic            tick_o
);
  localparam int unsigned MAX_SH = (1 << TB_W) - 1;
  localparam int unsigned DIV_W  = PRE_LOG2 + MAX_SH;

  logic [DIV_W-1:0] div_q;
  logic [DIV_W-1:0] term;
  logic [TB_W-1:0]  sh;

  // terminal count = 2^(PRE_LOG2+tb) - 1
  always_comb begin
    sh   = TB_W'(MAX_SH) - tb_i;
    term = {DIV_W{1'b1}} >> sh;
  end

  assign tick_o = run_i && (div_q == term);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              div_q <= '0;
    else if (clr_i || !run_i) div_q <= '0;
    else if (tick_o)          div_q <= '0;
    else                      div_q <= div_q + DIV_W'(1);
  end

  // R4
  tick_gap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick_o |=> !tick_o);
endmodule

// File: rtl/wdg_cfg_regs.sv
module wdg_cfg_regs
  import wdg_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             cfg_we_i,
  input  logic [CFG_W-1:0] cfg_wdata_i,
  input  logic             sts_we_i,
  input  logic             sts_wdata_i,
  input  logic             warn_set_i,
  output cfg_t             cfg_o,
  output logic             flag_o
);
  cfg_t cfg_q;
  logic flag_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cfg_q.irq_en <= 1'b0;
      cfg_q.tb     <= '0;
      cfg_q.win    <= CNT_RST;
    end else if (cfg_we_i) begin
      cfg_q <= cfg_t'(cfg_wdata_i);
    end
  end

  // hardware set wins over software clear
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                      flag_q <= 1'b0;
    else if (warn_set_i)              flag_q <= 1'b1;
    else if (sts_we_i && !sts_wdata_i) flag_q <= 1'b0;
  end

  assign cfg_o  = cfg_q;
  assign flag_o = flag_q;

  // R9
  flag_rise_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(flag_q) |-> $past(warn_set_i));

  // R9
  flag_keep_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flag_q && sts_we_i && sts_wdata_i |=> flag_q);
endmodule

// File: rtl/wdg_core.sv
module wdg_core
  import wdg_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             ctl_we_i,
  input  logic [CTL_W-1:0] ctl_wdata_i,
  input  logic             tick_i,
  input  logic [CNT_W-1:0] win_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             en_o,
  output logic             warn_set_o,
  output logic             rst_req_o
);
  logic [CNT_W-1:0] cnt_q;
  logic             en_q;
  logic             rst_q;
  logic             en_nxt;
  logic             early_hit;
  logic             bad_load;
  logic             expire_hit;

  always_comb begin
    en_nxt     = en_q | (ctl_we_i & ctl_wdata_i[CTL_W-1]);
    early_hit  = ctl_we_i & en_q & (cnt_q > win_i);
    bad_load   = ctl_we_i & en_nxt & ~ctl_wdata_i[CNT_W-1];
    expire_hit = ~ctl_we_i & tick_i & (cnt_q == CNT_EDGE);
    warn_set_o = ~ctl_we_i & tick_i & (cnt_q == CNT_EDGE + CNT_W'(1));
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= CNT_RST;
      en_q  <= 1'b0;
      rst_q <= 1'b0;
    end else begin
      en_q  <= en_nxt;
      rst_q <= early_hit | bad_load | expire_hit;
      if (ctl_we_i)    cnt_q <= ctl_wdata_i[CNT_W-1:0];
      else if (tick_i) cnt_q <= cnt_q - CNT_W'(1);
    end
  end

  assign cnt_o     = cnt_q;
  assign en_o      = en_q;
  assign rst_req_o = rst_q;

  // R2
  en_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    en_q |=> en_q);

  // R3
  frozen_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_q && !ctl_we_i |=> $stable(cnt_q) && !rst_q);

  // R4
  cnt_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ctl_we_i |=> (cnt_q == $past(cnt_q)) || (cnt_q == $past(cnt_q) - CNT_W'(1)));

  // R5
  expire_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(cnt_q[CNT_W-1]) && !$past(ctl_we_i) |-> rst_q);
endmodule

// File: rtl/win_wdog.sv
module win_wdog
  import wdg_pkg::*;
#(
  parameter int unsigned PRE_LOG2 = 12
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             ctl_we_i,
  input  logic [CTL_W-1:0] ctl_wdata_i,
  input  logic             cfg_we_i,
  input  logic [CFG_W-1:0] cfg_wdata_i,
  input  logic             sts_we_i,
  input  logic             sts_wdata_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             en_o,
  output logic             ewi_flag_o,
  output logic             irq_o,
  output logic             sys_rst_o
);
  cfg_t cfg;
  logic tick;
  logic en;
  logic warn_set;

  wdg_cfg_regs i_regs (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .cfg_we_i    (cfg_we_i),
    .cfg_wdata_i (cfg_wdata_i),
    .sts_we_i    (sts_we_i),
    .sts_wdata_i (sts_wdata_i),
    .warn_set_i  (warn_set),
    .cfg_o       (cfg),
    .flag_o      (ewi_flag_o)
  );

  wdg_prescaler #(.PRE_LOG2(PRE_LOG2)) i_pre (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .run_i  (en),
    .clr_i  (ctl_we_i),
    .tb_i   (cfg.tb),
    .tick_o (tick)
  );

  wdg_core i_core (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .ctl_we_i    (ctl_we_i),
    .ctl_wdata_i (ctl_wdata_i),
    .tick_i      (tick),
    .win_i       (cfg.win),
    .cnt_o       (cnt_o),
    .en_o        (en),
    .warn_set_o  (warn_set),
    .rst_req_o   (sys_rst_o)
  );

  assign en_o  = en;
  assign irq_o = ewi_flag_o & cfg.irq_en;

  // R10
  irq_drop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(ewi_flag_o) |-> !irq_o);
endmodule

// File: tb/test_win_wdog.sv
module test_win_wdog;
  localparam int PRE_LOG2 = 2;

  logic       clk = 1'b0;
  logic       rst_ni = 1'b0;
  logic       ctl_we = 1'b0;
  logic [7:0] ctl_wd = '0;
  logic       cfg_we = 1'b0;
  logic [9:0] cfg_wd = '0;
  logic       sts_we = 1'b0;
  logic       sts_wd = 1'b0;
  logic [6:0] cnt;
  logic       en, flag, irq, srst;

  int total = 0;
  int bad = 0;

  always #10 clk = ~clk;

  win_wdog #(.PRE_LOG2(PRE_LOG2)) i_win_wdog (
    .clk_i(clk), .rst_ni(rst_ni),
    .ctl_we_i(ctl_we), .ctl_wdata_i(ctl_wd),
    .cfg_we_i(cfg_we), .cfg_wdata_i(cfg_wd),
    .sts_we_i(sts_we), .sts_wdata_i(sts_wd),
    .cnt_o(cnt), .en_o(en), .ewi_flag_o(flag), .irq_o(irq), .sys_rst_o(srst)
  );

  function automatic int tick_len(int tb);
    return (1 << PRE_LOG2) << tb;
  endfunction

  function automatic int early_hit(int cur, int win);
    return (cur > win) ? 1 : 0;
  endfunction

  task automatic chk(input string req, input int act, input int exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  // all tasks start and end on a falling edge
  task automatic do_reset();
    rst_ni = 1'b0;
    repeat (2) @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);
  endtask

  task automatic wr_ctl(input logic [7:0] d);
    ctl_we = 1'b1; ctl_wd = d;
    @(negedge clk);
    ctl_we = 1'b0;
  endtask

  task automatic wr_cfg(input logic [9:0] d);
    cfg_we = 1'b1; cfg_wd = d;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic wr_sts(input logic d);
    sts_we = 1'b1; sts_wd = d;
    @(negedge clk);
    sts_we = 1'b0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog timeout");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed_0017));
    @(negedge clk);
    do_reset();

    // R1 reset state
    chk("R1 cnt", int'(cnt), 'h7F);
    chk("R1 en", int'(en), 0);
    chk("R1 flag", int'(flag), 0);
    chk("R1 irq", int'(irq), 0);
    chk("R1 rst", int'(srst), 0);

    // R3 disabled: counter frozen, loads without enabling
    repeat (100) @(negedge clk);
    chk("R3 cnt hold", int'(cnt), 'h7F);
    wr_ctl(8'h55);
    chk("R3 load no en", int'(en), 0);
    chk("R3 load no rst", int'(srst), 0);
    repeat (50) @(negedge clk);
    chk("R3 cnt hold2", int'(cnt), 'h55);
    chk("R3 no rst", int'(srst), 0);

    // R2/R7 enable sticky, in-window refresh accepted
    do_reset();
    wr_ctl(8'hFF);
    chk("R2 en set", int'(en), 1);
    wr_ctl(8'h7F);
    chk("R2 en kept", int'(en), 1);
    chk("R7 cnt loaded", int'(cnt), 'h7F);
    chk("R7 no rst", int'(srst), 0);

    // R4 R5 R9 R10 expiry sequence, tb=0, irq on
    do_reset();
    wr_cfg(10'h27F);
    wr_ctl(8'hC5);
    repeat (4) @(negedge clk);
    chk("R4 first step", int'(cnt), 'h44);
    repeat (15) @(negedge clk);
    chk("R9 flag early", int'(flag), 0);
    chk("R10 irq early", int'(irq), 0);
    @(negedge clk);
    chk("R9 flag set", int'(flag), 1);
    chk("R10 irq set", int'(irq), 1);
    chk("R9 cnt edge", int'(cnt), 'h40);
    repeat (3) @(negedge clk);
    chk("R5 rst early", int'(srst), 0);
    @(negedge clk);
    chk("R5 rst pulse", int'(srst), 1);
    chk("R5 cnt after", int'(cnt), 'h3F);
    @(negedge clk);
    chk("R5 rst one cycle", int'(srst), 0);
    wr_sts(1'b1);
    chk("R9 write1 keeps", int'(flag), 1);
    wr_sts(1'b0);
    chk("R9 write0 clears", int'(flag), 0);
    chk("R10 irq cleared", int'(irq), 0);

    // R4 prescale code 2
    do_reset();
    wr_cfg(10'h17F);
    wr_ctl(8'hFF);
    repeat (tick_len(2) - 1) @(negedge clk);
    chk("R4 tb2 hold", int'(cnt), 'h7F);
    @(negedge clk);
    chk("R4 tb2 step", int'(cnt), 'h7E);

    // R8 load with top bit clear
    do_reset();
    wr_ctl(8'hA0);
    chk("R8 rst on enable", int'(srst), 1);
    do_reset();
    wr_ctl(8'hFF);
    wr_ctl(8'h3F);
    chk("R8 rst on refresh", int'(srst), 1);

    // R10 flag without interrupt enable
    do_reset();
    wr_ctl(8'hC1);
    repeat (tick_len(0)) @(negedge clk);
    chk("R10 flag set", int'(flag), 1);
    chk("R10 irq gated", int'(irq), 0);

    // R6 early refresh
    do_reset();
    wr_cfg(10'h050);
    wr_ctl(8'hFF);
    chk("R6 enable no rst", int'(srst), 0);
    wr_ctl(8'hFF);
    chk("R6 early rst", int'(srst), 1);

    // R6/R7 random refresh timing vs window
    for (int it = 0; it < 25; it++) begin
      int tb, win, v, n, cur, v2;
      tb  = int'($urandom_range(1, 0));
      win = int'($urandom_range(127, 0));
      v   = int'($urandom_range(127, 65));
      n   = int'($urandom_range(v - 64, 0));
      v2  = int'($urandom_range(127, 64));
      cur = v - n;
      do_reset();
      wr_cfg(10'(tb << 7 | win));
      wr_ctl(8'(v | 128));
      repeat (n * tick_len(tb)) @(negedge clk);
      chk("R4 rand cnt", int'(cnt), cur);
      wr_ctl(8'(v2 | 128));
      if (early_hit(cur, win) != 0) begin
        chk("R6 rand early", int'(srst), 1);
      end else begin
        chk("R7 rand ok", int'(srst), 0);
        chk("R7 rand load", int'(cnt), v2);
      end
    end

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule